// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects a parameterised set of interrupt request lines (256 by default) and keeps one sticky pending bit per source. Each source has a 6-bit priority and an enable bit. The block finds the most urgent eligible source and hands the processor a request together with the source number, its priority and a 16-bit vector offset.

Selection and vector generation are two separate register stages. The vector is therefore on the outputs as soon as the request is raised, before the core acknowledges it. The core can fetch from it while its pipeline is still draining.

The controller tracks the priority of the running handler on a small nesting stack. Only strictly more urgent requests may preempt that handler. At the end of a handler, the core can use a chain handshake to go straight to the next pending source, without returning to the interrupted code. A compatibility mode replaces the vectored request with eight direct interrupt lines.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A source becomes pending when its request line is high at a rising clock edge. It stays pending after the line falls, until it is acknowledged or cleared. The number of sources is set by NUM_SRC, up to 256.
- R2: Configuration op 0 writes cfgData[5:0] as the priority of source cfgIdx. A pending source with priority 0, or with its enable bit clear, never raises irqReq.
- R3: Among the eligible pending sources, the one with the highest priority is offered. When priorities are equal, the lower source number wins.
- R4: Configuration op 1 writes a spacing code from cfgData[1:0]. vecOffset equals the source number times 32, 64, 128 or 256 for codes 0, 1, 2 and 3.
- R5: Selection and vector generation are separate register stages. irqReq, irqId, irqPrio and vecOffset appear together at the third rising edge after the request line is sampled high, before any acknowledge.
- R6: irqReq is high only while the offered priority is strictly above the running priority. coreAck while irqReq is high (with eoi low) does three things: it makes the offered priority the running one, it nests the old running priority, and it clears that source's pending bit. coreAck while irqReq is low has no effect.
- R7: eoi without coreAck restores the running priority that was active before the current handler was taken.
- R8: During a handler, chainAvail is high when the offered source is more urgent than the priority that eoi would restore. eoi together with coreAck in that state moves directly to the offered source: the running priority becomes its priority, the nesting depth is unchanged, and its pending bit is cleared.
- R9: Configuration ops 2 and 3 set and clear the pending bit of source cfgIdx. Ops 4 and 5 set and clear its enable bit. No other source's bits change.
- R10: With compatMode high, hwIrq[k] is high for each source k from 0 to 7 that is pending, enabled and has a nonzero priority, and irqReq stays low.
- R11: After reset, no source is pending or enabled, all priorities and the spacing code are 0, and irqReq, chainAvail, hwIrq and vecOffset are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqIn | input | NUM_SRC | Interrupt request lines |
| cfgWe | input | 1 | Configuration write strobe |
| cfgOp | input | 3 | Configuration operation (0 to 5) |
| cfgIdx | input | ID_W | Source addressed by the operation |
| cfgData | input | 6 | Priority or spacing code |
| compatMode | input | 1 | Select eight direct interrupt lines |
| coreAck | input | 1 | Core takes the offered interrupt |
| eoi | input | 1 | Handler finished |
| irqReq | output | 1 | Vectored interrupt request |
| irqId | output | ID_W | Offered source number |
| irqPrio | output | 6 | Offered source priority |
| vecOffset | output | 16 | Vector offset of the offered source |
| chainAvail | output | 1 | A chained source is ready at handler end |
| hwIrq | output | 8 | Direct interrupt lines in compatibility mode |

## Verification
The bench drives two sources of equal priority at the same time. A controller that resolves ties toward the higher number offers the wrong vector first. It nests a more urgent handler and raises a mid-priority source under it. A design that compares against the wrong priority either preempts when it should wait, or fails to offer that source after eoi. Chained handoffs are checked for the new vector and for the nesting depth they leave behind. A design that pops the stack on a chain would let a later, lower-priority source slip through. Masking by priority 0, by the enable bit and by an atomic pending clear is checked at irqReq. The pipeline latency is counted edge by edge, so a design with a collapsed or extra stage shows up.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int PRIO_W = 6;

  typedef enum logic [2:0] {
    OP_PRIO     = 3'd0,
    OP_SPACING  = 3'd1,
    OP_PEND_SET = 3'd2,
    OP_PEND_CLR = 3'd3,
    OP_EN_SET   = 3'd4,
    OP_EN_CLR   = 3'd5
  } cfgOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic retire;   // offered source taken: clear its pending bit, flush stages
  } ctrlStrobe_t;
endpackage

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 256,
  parameter int VEC_W   = 16,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic              cfgWe,
  input  logic [2:0]        cfgOp,
  input  logic [ID_W-1:0]   cfgIdx,
  input  logic [PRIO_W-1:0] cfgData,
  input  logic              compatMode,
  input  ctrlStrobe_t       strobe,
  output logic              s2Valid,
  output logic [ID_W-1:0]   s2Id,
  output logic [PRIO_W-1:0] s2Prio,
  output logic [VEC_W-1:0]  vecOffset,
  output logic [7:0]        hwIrq
);
  localparam int SHIFT_BASE = 5;

  logic [NUM_SRC-1:0] pend, pendNext, enab, enabNext, eligible;
  logic [PRIO_W-1:0]  prioReg [NUM_SRC];
  logic [1:0]         spacing;
  logic               cfgPrio, cfgSpace;
  cfgOp_e             op;

  assign op       = cfgOp_e'(cfgOp);
  assign cfgPrio  = cfgWe && (op == OP_PRIO);
  assign cfgSpace = cfgWe && (op == OP_SPACING);

  // Pending and enable next state: acknowledge clear wins
  always_comb begin
    pendNext = pend | irqIn;
    enabNext = enab;
    if (cfgWe && op == OP_PEND_SET) pendNext[cfgIdx] = 1'b1;
    if (cfgWe && op == OP_PEND_CLR) pendNext[cfgIdx] = 1'b0;
    if (cfgWe && op == OP_EN_SET)   enabNext[cfgIdx] = 1'b1;
    if (cfgWe && op == OP_EN_CLR)   enabNext[cfgIdx] = 1'b0;
    if (strobe.retire)              pendNext[s2Id]   = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend    <= '0;
      enab    <= '0;
      spacing <= '0;
    end else begin
      pend <= pendNext;
      enab <= enabNext;
      if (cfgSpace) spacing <= cfgData[1:0];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         prioReg[i] <= '0;
      else if (cfgPrio && cfgIdx == ID_W'(i)) prioReg[i] <= cfgData;
    end
    assign eligible[i] = pend[i] && enab[i] && (prioReg[i] != '0);
  end

  // Stage 1: priority resolution, downward scan so ties go to lower index
  logic [PRIO_W-1:0] bestPrio;
  logic [ID_W-1:0]   bestId;
  always_comb begin
    bestPrio = '0;
    bestId   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i] && prioReg[i] >= bestPrio) begin
        bestPrio = prioReg[i];
        bestId   = ID_W'(i);
      end
    end
  end

  logic              s1Valid;
  logic [ID_W-1:0]   s1Id;
  logic [PRIO_W-1:0] s1Prio;
  logic [VEC_W-1:0]  vecNext;

  // Stage 2: vector generation from the resolved source
  assign vecNext = VEC_W'(s1Id) << (SHIFT_BASE + int'(spacing));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid   <= 1'b0;
      s1Id      <= '0;
      s1Prio    <= '0;
      s2Valid   <= 1'b0;
      s2Id      <= '0;
      s2Prio    <= '0;
      vecOffset <= '0;
    end else if (strobe.retire) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid   <= bestPrio != '0;
      s1Id      <= bestId;
      s1Prio    <= bestPrio;
      s2Valid   <= s1Valid;
      s2Id      <= s1Id;
      s2Prio    <= s1Prio;
      vecOffset <= vecNext;
    end
  end

  for (genvar k = 0; k < 8; k++) begin : gCompat
    assign hwIrq[k] = compatMode && eligible[k];
  end
endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
#(
  parameter int NEST_DEPTH = 8,
  localparam int IDX_W  = $clog2(NEST_DEPTH),
  localparam int DCNT_W = $clog2(NEST_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreAck,
  input  logic              eoi,
  input  logic              compatMode,
  input  logic              s2Valid,
  input  logic [PRIO_W-1:0] s2Prio,
  output logic              irqReq,
  output logic              chainAvail,
  output logic [PRIO_W-1:0] runPrio,
  output ctrlStrobe_t       strobe
);
  logic [PRIO_W-1:0] prioStack [NEST_DEPTH];
  logic [DCNT_W-1:0] nestDepth;
  logic [PRIO_W-1:0] topPrio;
  logic              takeGo, chainGo, popGo, nested;

  assign nested  = nestDepth != '0;
  assign topPrio = nested ? prioStack[IDX_W'(nestDepth - 1'b1)] : '0;

  assign irqReq     = !compatMode && s2Valid && (s2Prio > runPrio)
                      && (nestDepth < DCNT_W'(NEST_DEPTH));
  assign chainAvail = !compatMode && nested && s2Valid && (s2Prio > topPrio);

  assign takeGo  = coreAck && !eoi && irqReq;
  assign chainGo = coreAck && eoi && chainAvail;
  assign popGo   = eoi && !chainGo && nested;

  assign strobe.retire = takeGo || chainGo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runPrio   <= '0;
      nestDepth <= '0;
      for (int i = 0; i < NEST_DEPTH; i++) prioStack[i] <= '0;
    end else if (takeGo) begin
      prioStack[IDX_W'(nestDepth)] <= runPrio;
      nestDepth <= nestDepth + 1'b1;
      runPrio   <= s2Prio;
    end else if (chainGo) begin
      runPrio <= s2Prio;
    end else if (popGo) begin
      runPrio   <= topPrio;
      nestDepth <= nestDepth - 1'b1;
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC    = 256,
  parameter int NEST_DEPTH = 8,
  parameter int VEC_W      = 16,
  localparam int ID_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               cfgWe,
  input  logic [2:0]         cfgOp,
  input  logic [ID_W-1:0]    cfgIdx,
  input  logic [PRIO_W-1:0]  cfgData,
  input  logic               compatMode,
  input  logic               coreAck,
  input  logic               eoi,
  output logic               irqReq,
  output logic [ID_W-1:0]    irqId,
  output logic [PRIO_W-1:0]  irqPrio,
  output logic [VEC_W-1:0]   vecOffset,
  output logic               chainAvail,
  output logic [7:0]         hwIrq
);
  ctrlStrobe_t       strobe;
  logic              s2Valid;
  logic [PRIO_W-1:0] runPrio;

  vic_datapath #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) uDp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .cfgWe(cfgWe), .cfgOp(cfgOp), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .compatMode(compatMode), .strobe(strobe),
    .s2Valid(s2Valid), .s2Id(irqId), .s2Prio(irqPrio),
    .vecOffset(vecOffset), .hwIrq(hwIrq)
  );

  vic_control #(.NEST_DEPTH(NEST_DEPTH)) uCtl (
    .clk(clk), .rstN(rstN), .coreAck(coreAck), .eoi(eoi),
    .compatMode(compatMode), .s2Valid(s2Valid), .s2Prio(irqPrio),
    .irqReq(irqReq), .chainAvail(chainAvail), .runPrio(runPrio),
    .strobe(strobe)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              irqReq,
  input logic [PRIO_W-1:0] irqPrio,
  input logic [PRIO_W-1:0] runPrio,
  input logic              coreAck,
  input logic              eoi,
  input logic              compatMode
);
  assert_req_above_running_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqPrio > runPrio));

  assert_take_sets_prio_R6: assert property (@(posedge clk) disable iff (!rstN)
    (coreAck && !eoi && irqReq) |=> (runPrio == $past(irqPrio)));

  assert_retire_flushes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (coreAck && irqReq) |=> !irqReq);

  assert_eoi_lowers_prio_R7: assert property (@(posedge clk) disable iff (!rstN)
    (eoi && !coreAck && runPrio != '0) |=> (runPrio < $past(runPrio)));

  assert_compat_no_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    compatMode |-> !irqReq);
endmodule

bind vec_irq_ctrl vic_checker uChk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqPrio(irqPrio),
  .runPrio(runPrio), .coreAck(coreAck), .eoi(eoi), .compatMode(compatMode)
);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  localparam int NUM_SRC = 256;
  localparam int ID_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_SRC-1:0] irqIn = '0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgOp = '0;
  logic [ID_W-1:0] cfgIdx = '0;
  logic [5:0] cfgData = '0;
  logic compatMode = 1'b0, coreAck = 1'b0, eoi = 1'b0;
  logic irqReq, chainAvail;
  logic [ID_W-1:0] irqId;
  logic [5:0] irqPrio;
  logic [15:0] vecOffset;
  logic [7:0] hwIrq;

  int nChecks = 0, nFails = 0, cycles = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .cfgWe(cfgWe), .cfgOp(cfgOp),
    .cfgIdx(cfgIdx), .cfgData(cfgData), .compatMode(compatMode),
    .coreAck(coreAck), .eoi(eoi), .irqReq(irqReq), .irqId(irqId),
    .irqPrio(irqPrio), .vecOffset(vecOffset), .chainAvail(chainAvail),
    .hwIrq(hwIrq)
  );

  typedef struct {
    int id; int prio; int vec; bit isChain; string tag;
  } expItem_t;
  expItem_t expQ[$];

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: compare the offered interrupt with the scoreboard head
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      bit bad;
      e = expQ.pop_front();
      nChecks++;
      bad = (e.isChain ? !chainAvail : !irqReq) || int'(irqId) != e.id
            || int'(irqPrio) != e.prio || int'(vecOffset) != e.vec;
      if (bad) begin
        nFails++;
        $display("FAIL %s: actual req=%0d chain=%0d id=%0d prio=%0d vec=%0d expected id=%0d prio=%0d vec=%0d",
                 e.tag, irqReq, chainAvail, irqId, irqPrio, vecOffset, e.id, e.prio, e.vec);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic settle();
    repeat (4) tick();
  endtask

  task automatic cfg(int op, int idx, int data);
    cfgWe = 1'b1; cfgOp = 3'(op); cfgIdx = ID_W'(idx); cfgData = 6'(data);
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic setup(int idx, int prio);
    cfg(0, idx, prio);
    cfg(4, idx, 0);
  endtask

  task automatic pulse(int idx);
    irqIn[idx] = 1'b1;
    tick();
    irqIn[idx] = 1'b0;
  endtask

  task automatic endHandler();
    eoi = 1'b1;
    tick();
    eoi = 1'b0;
    settle();
  endtask

  // Driver: push the expected offer, let the monitor compare, then take it
  task automatic serve(int id, int prio, int vec, bit isChain, string tag);
    expItem_t e;
    e.id = id; e.prio = prio; e.vec = vec; e.isChain = isChain; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk); #1;
    coreAck = 1'b1; eoi = isChain;
    tick();
    coreAck = 1'b0; eoi = 1'b0;
    settle();
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R11 reset state
    check("R11 irqReq", int'(irqReq), 0);
    check("R11 chainAvail", int'(chainAvail), 0);
    check("R11 hwIrq", int'(hwIrq), 0);
    check("R11 vecOffset", int'(vecOffset), 0);

    // R3 tie goes to lower index; spacing code 0 = 32
    setup(5, 10); setup(9, 10); setup(200, 3);
    irqIn[9] = 1'b1; irqIn[5] = 1'b1; irqIn[200] = 1'b1;
    tick();
    irqIn = '0;
    settle();
    serve(5, 10, 160, 0, "R3 tie");
    check("R6 equal prio not offered", int'(irqReq), 0);
    check("R8 chainAvail", int'(chainAvail), 1);
    serve(9, 10, 288, 1, "R8 chain");
    cfg(1, 0, 3);
    settle();
    serve(200, 3, 51200, 1, "R4 spacing 256");
    check("R8 depth kept, none above", int'(irqReq), 0);
    endHandler();
    check("R7 idle after eoi", int'(irqReq), 0);

    // R1 sticky pending, R6 nesting, R7 restore
    setup(20, 5); setup(30, 40); setup(40, 20);
    pulse(20); settle();
    serve(20, 5, 5120, 0, "R1 sticky");
    pulse(30); settle();
    serve(30, 40, 7680, 0, "R6 preempt");
    pulse(40); settle();
    check("R6 lower prio waits", int'(irqReq), 0);
    check("R8 chainAvail above restored", int'(chainAvail), 1);
    endHandler();
    serve(40, 20, 10240, 0, "R7 restored prio");
    endHandler();
    endHandler();
    check("R7 all handlers done", int'(irqReq), 0);

    // R2 masking by priority 0 and by enable
    setup(50, 0);
    pulse(50); settle();
    check("R2 prio 0 masked", int'(irqReq), 0);
    cfg(0, 60, 30);
    pulse(60); settle();
    check("R2 disabled masked", int'(irqReq), 0);
    cfg(4, 60, 0);
    settle();
    serve(60, 30, 15360, 0, "R9 enable set keeps pending");
    endHandler();

    // R9 atomic pending set and clear
    setup(70, 12);
    cfg(2, 70, 0); settle();
    serve(70, 12, 17920, 0, "R9 pending set");
    endHandler();
    setup(71, 12);
    cfg(2, 71, 0); cfg(3, 71, 0); settle();
    check("R9 pending clear", int'(irqReq), 0);

    // R6 stray acknowledge ignored
    coreAck = 1'b1; tick(); coreAck = 1'b0; settle();
    setup(80, 1);
    pulse(80); settle();
    serve(80, 1, 20480, 0, "R6 stray ack ignored");
    endHandler();

    // R5 latency count
    setup(90, 9);
    pulse(90);
    check("R5 after edge 1", int'(irqReq), 0);
    tick();
    check("R5 after edge 2", int'(irqReq), 0);
    tick();
    check("R5 after edge 3", int'(irqReq), 1);
    serve(90, 9, 23040, 0, "R5 vector before ack");
    endHandler();

    // R10 compatibility mode
    compatMode = 1'b1;
    setup(3, 7);
    pulse(3); settle();
    check("R10 hwIrq", int'(hwIrq), 8);
    check("R10 no vectored req", int'(irqReq), 0);
    cfg(3, 3, 0); settle();
    check("R10 hwIrq cleared", int'(hwIrq), 0);
    compatMode = 1'b0;
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule